// File: doc/BRIEF.md
# Sync Delay-Lock and Divider Phase Controller

This controller brings a converter's divide-by-4 clock into step with a system-wide sync pulse. In master mode, a start request launches a search. The search steps a 6-bit tap code for the sync-output delay line upward from zero and reads three window samples (early, center, late) once per evaluation interval. It stops at the first tap where the sync edge sits centered in the window. It then derives a 2-bit sync-output phase select from the locked tap. On the next sampled sync pulse, it captures the divide-by-4 phase. After that it enters tracking, where the tap is nudged up or down as the edge drifts.

In slave mode there is no search and no tracking. The controller waits for the incoming sync, captures the divider phase from it, and reports lock. The delay line, the window samplers and the sync fanout lie outside the block. Here they are only stimulus.

Top module: `sync_lock_ctrl`

## Requirements
- R1: While `rst` is high, at the next rising edge the block goes idle. At that edge `tap`, `so_sel` and `div_phase` become 0, and `locked`, `tracking` and `lock_err` become 0.
- R2: A master-mode start (sampled with `master_mode`=1) sets `tap` to 0. `tap` then rises by exactly one tap every 16 clocks. Each step is taken at an evaluation edge, which falls 16·k edges after the start edge, whenever the samples there are not centered.
- R3: The window is centered when `win_early`=0, `win_center`=1 and `win_late`=1. A centered evaluation ends the search. `tap` then holds its value until tracking begins.
- R4: If the evaluation at tap 63 is not centered, `lock_err` rises at that evaluation edge, the block returns to idle, `tap` stays 63, and `locked` stays 0.
- R5: One clock after the search locks, `so_sel` takes the two most significant bits of the locked `tap`.
- R6: After phase selection, the first clock edge with `sync_in`=1 loads `div_phase` with a 2-bit count. This count is 0 on the first edge after reset and advances by one every clock. The same edge sets `locked` and `tracking`. `div_phase` then holds while `locked` stays high.
- R7: In tracking, evaluations fall every 16 clocks, counted from the capture edge. An early indication (`win_early`=1) seen on 4 consecutive evaluations raises `tap` by one at the 4th. A late indication (`win_early`=0, `win_late`=0) seen on 4 consecutive evaluations lowers `tap` by one.
- R8: A centered evaluation in tracking resets the run of consecutive indications, so three early evaluations, one centered evaluation, then three early evaluations leave `tap` unchanged.
- R9: A slave-mode start (`master_mode`=0) clears `tap` to 0. The block then performs no search and no tracking. The first `sync_in`=1 edge loads `div_phase` as in R6 and sets `locked`. `tracking` stays 0 and `tap` stays 0 whatever the window samples show.
- R10: `start` is ignored while a search, phase selection, alignment wait or slave wait is in progress.
- R11: A start accepted from idle, tracking or slave lock clears `lock_err`, `locked` and `tracking` at its edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Run clock |
| rst | input | 1 | Synchronous reset, active high |
| master_mode | input | 1 | 1 = master (search and track), 0 = slave; sampled with start |
| start | input | 1 | Start request |
| sync_in | input | 1 | Sampled incoming sync pulse |
| win_early | input | 1 | Early window sample |
| win_center | input | 1 | Center window sample |
| win_late | input | 1 | Late window sample |
| tap | output | 6 | Delay-line tap code for the sync output |
| so_sel | output | 2 | Sync-output phase select |
| div_phase | output | 2 | Divide-by-4 clock phase |
| locked | output | 1 | Sync position and divider phase established |
| tracking | output | 1 | Continuous delay adjustment active |
| lock_err | output | 1 | Search ran off the top tap without centering |

## Verification
The hardest state to reach is a tracking run that is broken by a centered evaluation just before its fourth step. Reaching it needs window samples that change between particular 16-clock evaluations, all counted from the capture edge. The bench models the sampler as a function of the live `tap` output and a movable target tap. By moving the target at mid-interval cycles, it builds runs of early, late and centered evaluations. A search with an unreachable target drives the tap to the top code for the error path.

// File: rtl/sync_lock_ctrl.sv
module sync_lock_ctrl #(
  parameter int TAP_W    = 6,
  parameter int EVAL_LEN = 16,
  parameter int HYST     = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             master_mode,
  input  logic             start,
  input  logic             sync_in,
  input  logic             win_early,
  input  logic             win_center,
  input  logic             win_late,
  output logic [TAP_W-1:0] tap,
  output logic [1:0]       so_sel,
  output logic [1:0]       div_phase,
  output logic             locked,
  output logic             tracking,
  output logic             lock_err
);
  localparam int EV_W = $clog2(EVAL_LEN);
  localparam int HS_W = $clog2(HYST);
  localparam logic [TAP_W-1:0] TAP_MAX = {TAP_W{1'b1}};

  typedef enum logic [2:0] {
    S_IDLE, S_SEARCH, S_PHASE, S_ALIGN, S_TRACK, S_SWAIT, S_SLOCK
  } st_t;

  st_t             st;
  logic [1:0]      q_cnt;
  logic [EV_W-1:0] ev;
  logic [HS_W-1:0] hs;
  logic            hdir;

  wire eval_now  = (ev == EV_W'(EVAL_LEN - 1));
  wire centered  = !win_early && win_center && win_late;
  wire ind_early = win_early;
  wire ind_late  = !win_early && !win_late;
  wire can_start = (st == S_IDLE) || (st == S_TRACK) || (st == S_SLOCK);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      q_cnt     <= '0;
      ev        <= '0;
      hs        <= '0;
      hdir      <= 1'b0;
      tap       <= '0;
      so_sel    <= '0;
      div_phase <= '0;
      locked    <= 1'b0;
      tracking  <= 1'b0;
      lock_err  <= 1'b0;
    end else begin
      q_cnt <= q_cnt + 2'd1;
      ev    <= eval_now ? '0 : ev + 1'b1;
      if (start && can_start) begin
        tap      <= '0;
        locked   <= 1'b0;
        tracking <= 1'b0;
        lock_err <= 1'b0;
        ev       <= '0;
        hs       <= '0;
        st       <= master_mode ? S_SEARCH : S_SWAIT;
      end else begin
        case (st)
          S_SEARCH: if (eval_now) begin
            if (centered)            st <= S_PHASE;
            else if (tap == TAP_MAX) begin
              lock_err <= 1'b1;
              st       <= S_IDLE;
            end else                 tap <= tap + 1'b1;
          end
          S_PHASE: begin
            so_sel <= tap[TAP_W-1 -: 2];
            st     <= S_ALIGN;
          end
          S_ALIGN: if (sync_in) begin
            div_phase <= q_cnt;
            locked    <= 1'b1;
            tracking  <= 1'b1;
            ev        <= '0;
            hs        <= '0;
            st        <= S_TRACK;
          end
          S_TRACK: if (eval_now) begin
            if (ind_early || ind_late) begin
              if (hs != '0 && hdir == ind_early) begin
                if (hs == HS_W'(HYST - 1)) begin
                  hs <= '0;
                  if (ind_early && tap != TAP_MAX) tap <= tap + 1'b1;
                  else if (!ind_early && tap != '0) tap <= tap - 1'b1;
                end else hs <= hs + 1'b1;
              end else begin
                hdir <= ind_early;
                hs   <= HS_W'(1);
              end
            end else hs <= '0;
          end
          S_SWAIT: if (sync_in) begin
            div_phase <= q_cnt;
            locked    <= 1'b1;
            st        <= S_SLOCK;
          end
          default: ;
        endcase
      end
    end
  end

  a_r2_tap_step: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (tap == $past(tap)) || (tap == $past(tap) + 1'b1) ||
             (tap == $past(tap) - 1'b1) || (tap == '0));

  a_r3_tap_hold: assert property (@(posedge clk) disable iff (rst)
    (st == S_ALIGN || st == S_SWAIT || st == S_SLOCK) && ($past(st) == st)
      |-> $stable(tap));

  a_r4_err_unlocked: assert property (@(posedge clk) disable iff (rst)
    lock_err |-> !locked && !tracking);

  a_r6_phase_hold: assert property (@(posedge clk) disable iff (rst)
    locked && $past(locked) |-> $stable(div_phase));

  a_r6_track_needs_lock: assert property (@(posedge clk) disable iff (rst)
    tracking |-> locked);

  a_r7_move_on_eval: assert property (@(posedge clk) disable iff (rst)
    tracking && $past(tracking) && (tap != $past(tap)) |-> $past(eval_now));

  a_r9_slave_idle_tap: assert property (@(posedge clk) disable iff (rst)
    locked && !tracking |-> tap == '0);
endmodule

// File: tb/sync_lock_ctrl_tb.sv
module sync_lock_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       master_mode = 1'b1;
  logic       start = 1'b0;
  logic       sync_in = 1'b0;
  logic       win_early, win_center, win_late;
  logic [5:0] tap;
  logic [1:0] so_sel, div_phase;
  logic       locked, tracking, lock_err;

  int target = 0;
  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  always @(posedge clk) cyc <= rst ? 0 : cyc + 1;

  assign win_early  = (int'(tap) <  target);
  assign win_center = (int'(tap) <= target);
  assign win_late   = (int'(tap) <= target);

  sync_lock_ctrl u_dut (
    .clk(clk), .rst(rst), .master_mode(master_mode), .start(start),
    .sync_in(sync_in), .win_early(win_early), .win_center(win_center),
    .win_late(win_late), .tap(tap), .so_sel(so_sel), .div_phase(div_phase),
    .locked(locked), .tracking(tracking), .lock_err(lock_err)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic wait_to(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic pulse_start(input bit mst, output int c0);
    master_mode = mst;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    c0 = cyc;
  endtask

  task automatic capture(output int ca, output int exp_ph);
    sync_in = 1'b1;
    exp_ph = cyc % 4;
    @(negedge clk);
    sync_in = 1'b0;
    ca = cyc;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check("R1 tap", tap, 0);
    check("R1 so_sel", so_sel, 0);
    check("R1 div_phase", div_phase, 0);
    check("R1 flags", {locked, tracking, lock_err}, 0);
    rst = 1'b0;
  endtask

  int ca;

  task automatic t_search_track();
    int c0, ph;
    target = 21;
    pulse_start(1'b1, c0);
    check("R2 tap after start", tap, 0);
    wait_to(c0 + 15); check("R2 tap before first eval", tap, 0);
    wait_to(c0 + 16); check("R2 first step", tap, 1);
    wait_to(c0 + 32); check("R2 second step", tap, 2);
    wait_to(c0 + 40);
    pulse_start(1'b1, ph);
    wait_to(c0 + 48); check("R10 start ignored in search", tap, 3);
    wait_to(c0 + 336); check("R2 tap reaches 21", tap, 21);
    wait_to(c0 + 360);
    check("R3 tap held after lock", tap, 21);
    check("R5 so_sel from tap msbs", so_sel, 1);
    check("R6 not locked before sync", locked, 0);
    pulse_start(1'b1, ph);
    check("R10 start ignored in align", {locked, tracking}, 0);
    check("R3 tap held in align", tap, 21);
    capture(ca, ph);
    check("R6 div_phase capture", div_phase, ph);
    check("R6 locked", locked, 1);
    check("R6 tracking", tracking, 1);
    wait_to(ca + 8);  target = 22;
    wait_to(ca + 63); check("R7 no early move before 4th", tap, 21);
    wait_to(ca + 64); check("R7 early run raises tap", tap, 22);
    wait_to(ca + 72); target = 21;
    wait_to(ca + 127); check("R7 no late move before 4th", tap, 22);
    wait_to(ca + 128); check("R7 late run lowers tap", tap, 21);
    wait_to(ca + 136); target = 22;
    wait_to(ca + 184); target = 21;
    wait_to(ca + 200); target = 22;
    wait_to(ca + 247); check("R8 broken run holds tap", tap, 21);
    wait_to(ca + 256); check("R8 fresh run of 4 moves", tap, 22);
    check("R6 div_phase held", div_phase, ph);
  endtask

  task automatic t_fail();
    int c0;
    target = 70;
    pulse_start(1'b1, c0);
    check("R11 restart clears locked", {locked, tracking}, 0);
    wait_to(c0 + 1023);
    check("R4 tap at top", tap, 63);
    check("R4 no error yet", lock_err, 0);
    wait_to(c0 + 1024);
    check("R4 error raised", lock_err, 1);
    check("R4 not locked", locked, 0);
    wait_to(c0 + 1040);
    check("R4 tap stays at top in idle", tap, 63);
  endtask

  task automatic t_zero_lock();
    int c0, ph;
    target = 0;
    pulse_start(1'b1, c0);
    check("R11 start clears error", lock_err, 0);
    check("R2 tap cleared", tap, 0);
    wait_to(c0 + 19);
    check("R3 lock at tap 0", tap, 0);
    check("R5 so_sel for tap 0", so_sel, 0);
    @(negedge clk);
    capture(ca, ph);
    check("R6 second div_phase capture", div_phase, ph);
    check("R6 locked again", {locked, tracking}, 3);
  endtask

  task automatic t_slave();
    int c0, ph;
    target = 70;
    pulse_start(1'b0, c0);
    check("R11 slave start clears flags", {locked, tracking}, 0);
    wait_to(c0 + 50);
    check("R9 no search in slave", tap, 0);
    check("R9 waiting, not locked", locked, 0);
    @(negedge clk); @(negedge clk);
    capture(ca, ph);
    check("R9 slave div_phase", div_phase, ph);
    check("R9 slave locked", locked, 1);
    check("R9 slave not tracking", tracking, 0);
    wait_to(ca + 100);
    check("R9 slave tap unaffected", tap, 0);
    check("R9 slave still not tracking", tracking, 0);
  endtask

  initial begin
    t_reset();
    t_search_track();
    t_fail();
    t_zero_lock();
    t_slave();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule